// File: doc/BRIEF.md
# Cooperative Spill Replacement Unit

This unit manages the replacement of one set in a private cache that cooperates with peer caches. Each way stores a line address, its data and two extra flags. The first flag marks the line as the only copy on chip (singlet) or as a copy that also exists elsewhere (replicate). The second flag marks a line that arrived from a peer and has not been touched since.

When an access misses and the set is full, the unit chooses a victim. With a programmable probability it takes the oldest replicate, and otherwise it takes the least recently used way. What happens to the evicted line depends on its flags:
- An unique line is pushed out to a peer cache with a recirculation budget.
- A line that was pushed in and never reused spends one unit of its budget, or is dropped when the budget is gone.
- A replicate is discarded.

Lines pushed in by peers are placed at the LRU end of the set, so they survive only if they are reused before the set comes under pressure. Together the peer caches approximate one LRU order across all of them.

A directory notification port rewrites the singlet flag of a resident line. A configuration write sets the 8-bit preference threshold.

Top module: `coop_spill_unit`

## Requirements
- R1: After a synchronous reset:
  - all ways are empty and the threshold is 0;
  - the random source holds 0x01;
  - acc_hit_o and so_valid_o are low, and acc_way_o is 0;
  - the LRU order from MRU to LRU is way 0, way 1, way 2, way 3.
- R2: An access whose address matches a valid line gives acc_hit_o=1 and acc_way_o=that way one cycle later. The access moves that line to MRU and produces no spill.
- R3: A miss while some way is empty fills the lowest-numbered empty way and makes it MRU. acc_hit_o=0, acc_way_o reports that way, and nothing is spilled. The new line takes its singlet flag from acc_singlet_i and starts with its spilled-not-reused flag clear.
- R4: A miss in a full set reads the 8-bit random value V. If V <= threshold and at least one replicate line exists, the victim is the replicate closest to LRU. Otherwise the victim is the LRU way. V then steps once to {V[6:0], V[7]^V[5]^V[4]^V[3]}. No other event steps V.
- R5: Evicting a line whose spilled-not-reused flag is clear and whose singlet flag is set raises so_valid_o for one cycle, one cycle after the request. The spill carries the evicted address and data, with count RC_INIT (default 1).
- R6: Evicting a replicate line whose spilled-not-reused flag is clear produces no spill.
- R7: Evicting a line whose spilled-not-reused flag is set and whose stored count is c does one of two things:
  - if c > 1, it spills with count c-1;
  - if c <= 1, it drops the line with no spill.
- R8: A spill-in is written to the lowest empty way, or if the set is full to the LRU way. The evicted line follows R5 to R7. The new line is placed at the LRU position, with singlet set, spilled-not-reused set and the arriving count. A spill-in that arrives in the same cycle as an access is ignored.
- R9: A hit on a line clears its spilled-not-reused flag, so a later eviction of that line follows R5 or R6.
- R10: A notification whose address matches a valid line sets that line's singlet flag to nt_singlet_i. A notification that matches no line changes nothing.
- R11: A threshold written with cfg_we_i governs every miss from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Threshold write strobe |
| cfg_thresh_i | input | 8 | New replicate-preference threshold |
| acc_valid_i | input | 1 | Access or fill request |
| acc_addr_i | input | AW | Line address of the request |
| acc_data_i | input | DW | Fill data used on a miss |
| acc_singlet_i | input | 1 | Singlet flag given to a filled line |
| acc_hit_o | output | 1 | Request hit (registered) |
| acc_way_o | output | log2(WAYS) | Way hit or filled (registered) |
| si_valid_i | input | 1 | Spilled line arriving from a peer |
| si_addr_i | input | AW | Address of the arriving line |
| si_data_i | input | DW | Data of the arriving line |
| si_count_i | input | CW | Remaining recirculation count |
| nt_valid_i | input | 1 | Directory mode-change notification |
| nt_addr_i | input | AW | Address the notification refers to |
| nt_singlet_i | input | 1 | New singlet flag |
| so_valid_o | output | 1 | Line spilled to a peer (registered) |
| so_addr_o | output | AW | Spilled line address |
| so_data_o | output | DW | Spilled line data |
| so_count_o | output | CW | Count sent with the spilled line |

## Verification
The hardest case to reach is a line that came in by spill with a count above one and is later chosen as the victim without having been reused. To get there, the set must first fill up, the spilled line must drift to the LRU position, and a later miss must pick it over any replicates. The bench reaches this with a directed sequence at threshold 0, where the LRU way always loses. It then runs long pseudo-random mixes of hits, misses, spill-ins with counts 0 to 3, notifications and threshold changes against a model of the set. That model predicts every victim, the random value and every spill.

// File: rtl/csru_pkg.sv
package csru_pkg;
  typedef enum logic [1:0] {
    EV_NONE,
    EV_DROP,
    EV_FRESH,
    EV_RECIRC
  } ev_kind_e;

  function automatic logic [7:0] lfsr_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/csru_lfsr.sv
module csru_lfsr #(
  parameter logic [7:0] SEED = 8'h01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_i,
  output logic [7:0] value_o
);
  logic [7:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else if (step_i) state_q <= csru_pkg::lfsr_next(state_q);
  end

  assign value_o = state_q;

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != 8'h00);
endmodule

// File: rtl/csru_age_track.sv
module csru_age_track #(
  parameter int WAYS = 4,
  localparam int AGW = $clog2(WAYS),
  localparam int IW  = $clog2(WAYS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mru_en_i,
  input  logic                      lru_en_i,
  input  logic [IW-1:0]             way_i,
  output logic [WAYS-1:0][AGW-1:0]  age_o
);
  logic [WAYS-1:0][AGW-1:0] age_q;
  logic [AGW-1:0]           ref_age;

  assign ref_age = age_q[way_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= AGW'(i);
    end else if (mru_en_i) begin
      for (int i = 0; i < WAYS; i++) begin
        if (IW'(i) == way_i) age_q[i] <= '0;
        else if (age_q[i] < ref_age) age_q[i] <= age_q[i] + AGW'(1);
      end
    end else if (lru_en_i) begin
      for (int i = 0; i < WAYS; i++) begin
        if (IW'(i) == way_i) age_q[i] <= AGW'(WAYS - 1);
        else if (age_q[i] > ref_age) age_q[i] <= age_q[i] - AGW'(1);
      end
    end
  end

  assign age_o = age_q;

  logic [WAYS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < WAYS; i++) seen[age_q[i]] = 1'b1;
  end

  // R2
  age_perm_chk: assert property (@(posedge clk) disable iff (rst)
    &seen);
endmodule

// File: rtl/csru_victim.sv
module csru_victim #(
  parameter int WAYS = 4,
  localparam int AGW = $clog2(WAYS),
  localparam int IW  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]           valid_i,
  input  logic [WAYS-1:0]           singlet_i,
  input  logic [WAYS-1:0][AGW-1:0]  age_i,
  input  logic                      prefer_i,
  output logic                      full_o,
  output logic                      rep_any_o,
  output logic [IW-1:0]             acc_way_o,
  output logic [IW-1:0]             sin_way_o
);
  logic           free_found;
  logic [IW-1:0]  free_way;
  logic [IW-1:0]  lru_way;
  logic           rep_found;
  logic [IW-1:0]  rep_way;
  logic [AGW-1:0] rep_age;

  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_way   = IW'(i);
      end
    end
    lru_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (age_i[i] == AGW'(WAYS - 1)) lru_way = IW'(i);
    end
    rep_found = 1'b0;
    rep_way   = '0;
    rep_age   = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (valid_i[i] && !singlet_i[i] && (!rep_found || age_i[i] > rep_age)) begin
        rep_found = 1'b1;
        rep_way   = IW'(i);
        rep_age   = age_i[i];
      end
    end
  end

  assign full_o    = !free_found;
  assign rep_any_o = rep_found;
  assign acc_way_o = free_found ? free_way : ((prefer_i && rep_found) ? rep_way : lru_way);
  assign sin_way_o = free_found ? free_way : lru_way;
endmodule

// File: rtl/coop_spill_unit.sv
module coop_spill_unit #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int WAYS    = 4,
  parameter int CW      = 3,
  parameter int RC_INIT = 1,
  localparam int IW  = $clog2(WAYS),
  localparam int AGW = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we_i,
  input  logic [7:0]    cfg_thresh_i,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] acc_data_i,
  input  logic          acc_singlet_i,
  output logic          acc_hit_o,
  output logic [IW-1:0] acc_way_o,
  input  logic          si_valid_i,
  input  logic [AW-1:0] si_addr_i,
  input  logic [DW-1:0] si_data_i,
  input  logic [CW-1:0] si_count_i,
  input  logic          nt_valid_i,
  input  logic [AW-1:0] nt_addr_i,
  input  logic          nt_singlet_i,
  output logic          so_valid_o,
  output logic [AW-1:0] so_addr_o,
  output logic [DW-1:0] so_data_o,
  output logic [CW-1:0] so_count_o
);
  import csru_pkg::*;

  logic [WAYS-1:0]          valid_q, singlet_q, snr_q;
  logic [WAYS-1:0][AW-1:0]  tag_q;
  logic [WAYS-1:0][DW-1:0]  data_q;
  logic [WAYS-1:0][CW-1:0]  cnt_q;
  logic [7:0]               thresh_q;

  logic [WAYS-1:0][AGW-1:0] age;
  logic [7:0]               rnd;
  logic                     prefer, full, rep_any;
  logic [IW-1:0]            acc_vic, sin_vic;

  logic          hit, nt_hit;
  logic [IW-1:0] hit_way, nt_way;

  always_comb begin
    hit = 1'b0; hit_way = '0; nt_hit = 1'b0; nt_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (valid_q[i] && tag_q[i] == acc_addr_i) begin hit = 1'b1; hit_way = IW'(i); end
      if (valid_q[i] && tag_q[i] == nt_addr_i)  begin nt_hit = 1'b1; nt_way = IW'(i); end
    end
  end

  logic do_hit, do_fill, do_sin, evicting;
  logic [IW-1:0] tgt_way, ev_way;

  assign do_hit   = acc_valid_i && hit;
  assign do_fill  = acc_valid_i && !hit;
  assign do_sin   = si_valid_i && !acc_valid_i;
  assign evicting = (do_fill || do_sin) && full;
  assign ev_way   = do_fill ? acc_vic : sin_vic;
  assign tgt_way  = do_hit ? hit_way : ev_way;
  assign prefer   = rnd <= thresh_q;

  csru_lfsr u_lfsr (
    .clk(clk), .rst(rst), .step_i(do_fill && full), .value_o(rnd)
  );

  csru_age_track #(.WAYS(WAYS)) u_age (
    .clk(clk), .rst(rst), .mru_en_i(acc_valid_i), .lru_en_i(do_sin),
    .way_i(tgt_way), .age_o(age)
  );

  csru_victim #(.WAYS(WAYS)) u_victim (
    .valid_i(valid_q), .singlet_i(singlet_q), .age_i(age), .prefer_i(prefer),
    .full_o(full), .rep_any_o(rep_any), .acc_way_o(acc_vic), .sin_way_o(sin_vic)
  );

  ev_kind_e      ev_kind;
  logic [CW-1:0] ev_cnt;

  always_comb begin
    ev_kind = EV_NONE;
    ev_cnt  = '0;
    if (snr_q[ev_way]) begin
      if (cnt_q[ev_way] > CW'(1)) begin
        ev_kind = EV_RECIRC;
        ev_cnt  = cnt_q[ev_way] - CW'(1);
      end else begin
        ev_kind = EV_DROP;
      end
    end else if (singlet_q[ev_way]) begin
      ev_kind = EV_FRESH;
      ev_cnt  = CW'(RC_INIT);
    end
  end

  logic ev_spill;
  assign ev_spill = evicting && (ev_kind == EV_FRESH || ev_kind == EV_RECIRC);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= '0;
      singlet_q  <= '0;
      snr_q      <= '0;
      cnt_q      <= '0;
      thresh_q   <= '0;
      acc_hit_o  <= 1'b0;
      acc_way_o  <= '0;
      so_valid_o <= 1'b0;
      so_addr_o  <= '0;
      so_data_o  <= '0;
      so_count_o <= '0;
    end else begin
      if (cfg_we_i) thresh_q <= cfg_thresh_i;
      if (nt_valid_i && nt_hit) singlet_q[nt_way] <= nt_singlet_i;
      acc_hit_o  <= do_hit;
      if (acc_valid_i) acc_way_o <= tgt_way;
      so_valid_o <= ev_spill;
      if (ev_spill) begin
        so_addr_o  <= tag_q[ev_way];
        so_data_o  <= data_q[ev_way];
        so_count_o <= ev_cnt;
      end
      if (do_hit) snr_q[hit_way] <= 1'b0;
      if (do_fill) begin
        valid_q[acc_vic]   <= 1'b1;
        singlet_q[acc_vic] <= acc_singlet_i;
        snr_q[acc_vic]     <= 1'b0;
        cnt_q[acc_vic]     <= '0;
      end
      if (do_sin) begin
        valid_q[sin_vic]   <= 1'b1;
        singlet_q[sin_vic] <= 1'b1;
        snr_q[sin_vic]     <= 1'b1;
        cnt_q[sin_vic]     <= si_count_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[acc_vic]  <= acc_addr_i;
      data_q[acc_vic] <= acc_data_i;
    end else if (do_sin) begin
      tag_q[sin_vic]  <= si_addr_i;
      data_q[sin_vic] <= si_data_i;
    end
  end

  // R2
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    acc_hit_o |-> $past(acc_valid_i));
  // R5
  spill_cause_chk: assert property (@(posedge clk) disable iff (rst)
    so_valid_o |-> $past(acc_valid_i || si_valid_i));
  // R7
  count_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    so_valid_o |-> so_count_o != '0);
  // R6
  rep_discard_chk: assert property (@(posedge clk) disable iff (rst)
    (evicting && !snr_q[ev_way] && !singlet_q[ev_way]) |=> !so_valid_o);
  // R4
  rep_pref_chk: assert property (@(posedge clk) disable iff (rst)
    (do_fill && full && prefer && rep_any) |-> !singlet_q[acc_vic]);
  // R9
  hit_clears_snr_chk: assert property (@(posedge clk) disable iff (rst)
    do_hit |=> !snr_q[$past(hit_way)]);
endmodule

// File: tb/coop_spill_unit_bench.sv
module coop_spill_unit_bench;
  localparam int AW = 16, DW = 32, WAYS = 4, CW = 3, IW = 2;

  logic clk = 1'b0, rst = 1'b1;
  always #5ns clk = ~clk;

  logic          cfg_we_i = 0;
  logic [7:0]    cfg_thresh_i = 0;
  logic          acc_valid_i = 0, acc_singlet_i = 0;
  logic [AW-1:0] acc_addr_i = 0;
  logic [DW-1:0] acc_data_i = 0;
  logic          acc_hit_o;
  logic [IW-1:0] acc_way_o;
  logic          si_valid_i = 0;
  logic [AW-1:0] si_addr_i = 0;
  logic [DW-1:0] si_data_i = 0;
  logic [CW-1:0] si_count_i = 0;
  logic          nt_valid_i = 0, nt_singlet_i = 0;
  logic [AW-1:0] nt_addr_i = 0;
  logic          so_valid_o;
  logic [AW-1:0] so_addr_o;
  logic [DW-1:0] so_data_o;
  logic [CW-1:0] so_count_o;

  coop_spill_unit u_coop_spill_unit (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int         m_age[WAYS];
  bit         m_valid[WAYS], m_sing[WAYS], m_snr[WAYS];
  logic [15:0] m_tag[WAYS];
  logic [31:0] m_data[WAYS];
  int         m_cnt[WAYS];
  logic [7:0] m_lfsr, m_thr;
  int unsigned lcg = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rnd(input int m);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 8) % m);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < WAYS; i++) begin
      m_age[i] = i; m_valid[i] = 0; m_sing[i] = 0; m_snr[i] = 0; m_cnt[i] = 0;
    end
    m_lfsr = 8'h01; m_thr = 8'h00;
  endtask

  task automatic to_mru(input int w);
    int a = m_age[w];
    for (int i = 0; i < WAYS; i++)
      if (i == w) m_age[i] = 0; else if (m_age[i] < a) m_age[i]++;
  endtask

  task automatic to_lru(input int w);
    int a = m_age[w];
    for (int i = 0; i < WAYS; i++)
      if (i == w) m_age[i] = WAYS - 1; else if (m_age[i] > a) m_age[i]--;
  endtask

  function automatic int free_way();
    for (int i = 0; i < WAYS; i++) if (!m_valid[i]) return i;
    return -1;
  endfunction

  function automatic int lru_way();
    for (int i = 0; i < WAYS; i++) if (m_age[i] == WAYS - 1) return i;
    return 0;
  endfunction

  // expected spill of evicting way w (R5, R6, R7)
  task automatic evict_exp(input int w, output bit sp, output int cnt, output string req);
    sp = 0; cnt = 0;
    if (m_snr[w]) begin
      req = "R7";
      if (m_cnt[w] > 1) begin sp = 1; cnt = m_cnt[w] - 1; end
    end else if (m_sing[w]) begin
      req = "R5"; sp = 1; cnt = 1;
    end else req = "R6";
  endtask

  task automatic check_spill(input bit sp, input int cnt, input logic [15:0] a,
                             input logic [31:0] d, input string req);
    chk(so_valid_o == sp, req, so_valid_o, sp);
    if (sp) begin
      chk(so_addr_o == a, req, so_addr_o, a);
      chk(so_data_o == d, req, so_data_o, d);
      chk(so_count_o == CW'(cnt), req, so_count_o, cnt);
    end
  endtask

  // access; with_si drives a competing spill-in that must be ignored (R8)
  task automatic do_access(input logic [15:0] a, input logic [31:0] d, input bit s,
                           input bit with_si);
    int hw = -1, w;
    bit sp = 0; int cnt = 0; string req = "R3";
    logic [15:0] ea = 0; logic [31:0] ed = 0;
    for (int i = 0; i < WAYS; i++) if (m_valid[i] && m_tag[i] == a) hw = i;
    if (hw >= 0) begin
      w = hw; req = "R2"; to_mru(w); m_snr[w] = 0;
    end else begin
      w = free_way();
      if (w < 0) begin
        int rw = -1;
        for (int i = 0; i < WAYS; i++)
          if (!m_sing[i] && (rw < 0 || m_age[i] > m_age[rw])) rw = i;
        w = (m_lfsr <= m_thr && rw >= 0) ? rw : lru_way();
        m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
        evict_exp(w, sp, cnt, req);
        ea = m_tag[w]; ed = m_data[w];
      end
      m_valid[w] = 1; m_tag[w] = a; m_data[w] = d; m_sing[w] = s; m_snr[w] = 0; m_cnt[w] = 0;
      to_mru(w);
    end
    @(negedge clk);
    acc_valid_i = 1; acc_addr_i = a; acc_data_i = d; acc_singlet_i = s;
    if (with_si) begin si_valid_i = 1; si_addr_i = 16'hFFFF; si_data_i = 32'hDEAD; si_count_i = 3; end
    @(negedge clk);
    acc_valid_i = 0; si_valid_i = 0;
    chk(acc_hit_o == (hw >= 0), (hw >= 0) ? "R2" : "R4", acc_hit_o, hw >= 0);
    chk(acc_way_o == IW'(w), (hw >= 0) ? "R2" : "R4", acc_way_o, w);
    check_spill(sp, cnt, ea, ed, req);
  endtask

  task automatic do_spill_in(input logic [15:0] a, input logic [31:0] d, input int c);
    int w = free_way();
    bit sp = 0; int cnt = 0; string req = "R8";
    logic [15:0] ea = 0; logic [31:0] ed = 0;
    if (w < 0) begin
      w = lru_way(); evict_exp(w, sp, cnt, req); ea = m_tag[w]; ed = m_data[w];
    end
    m_valid[w] = 1; m_tag[w] = a; m_data[w] = d; m_sing[w] = 1; m_snr[w] = 1; m_cnt[w] = c;
    to_lru(w);
    @(negedge clk);
    si_valid_i = 1; si_addr_i = a; si_data_i = d; si_count_i = CW'(c);
    @(negedge clk);
    si_valid_i = 0;
    chk(acc_hit_o == 0, "R8", acc_hit_o, 0);
    check_spill(sp, cnt, ea, ed, req);
  endtask

  task automatic do_notify(input logic [15:0] a, input bit s);
    for (int i = 0; i < WAYS; i++) if (m_valid[i] && m_tag[i] == a) m_sing[i] = s;
    @(negedge clk);
    nt_valid_i = 1; nt_addr_i = a; nt_singlet_i = s;
    @(negedge clk);
    nt_valid_i = 0;
    chk(so_valid_o == 0, "R10", so_valid_o, 0);
  endtask

  task automatic set_thr(input logic [7:0] v);
    m_thr = v;
    @(negedge clk); cfg_we_i = 1; cfg_thresh_i = v;
    @(negedge clk); cfg_we_i = 0;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int next_si = 16'h0100;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(acc_hit_o == 0, "R1", acc_hit_o, 0);
    chk(acc_way_o == 0, "R1", acc_way_o, 0);
    chk(so_valid_o == 0, "R1", so_valid_o, 0);

    // R3 fills, R2 hits, R5/R6 evictions at threshold 0
    do_access(16'h10, 32'hA0, 1, 0);
    do_access(16'h11, 32'hA1, 0, 0);
    do_access(16'h12, 32'hA2, 1, 0);
    do_access(16'h13, 32'hA3, 0, 0);
    do_access(16'h10, 32'h0, 0, 0);
    do_access(16'h14, 32'hA4, 1, 0);
    do_access(16'h15, 32'hA5, 1, 0);
    // R7 directed: spill-in count 3 reaches LRU and is evicted with count 2
    do_spill_in(16'h0F00, 32'hBEEF, 3);
    do_access(16'h16, 32'hA6, 1, 0);
    // R9: spill-in reused, then evicted as fresh singlet
    do_spill_in(16'h0F01, 32'hCAFE, 2);
    do_access(16'h0F01, 32'h0, 0, 0);
    for (int k = 0; k < 4; k++) do_access(16'h20 + 16'(k), 32'hB0 + k, 1, 0);
    // R10 notification on resident and absent line
    do_notify(16'h21, 0);
    do_notify(16'h7777, 0);
    // R11 and R4: threshold sweep
    foreach (m_age[j]) begin end
    for (int t = 0; t < 4; t++) begin
      set_thr(t == 0 ? 8'd255 : (t == 1 ? 8'd128 : (t == 2 ? 8'd0 : 8'd64)));
      for (int n = 0; n < 150; n++) begin
        int op = rnd(16);
        if (op < 10) do_access(16'(rnd(8)), 32'(lcg), bit'(rnd(2)), op == 9);
        else if (op < 13) begin
          do_spill_in(16'(next_si), 32'(lcg), rnd(4));
          next_si++;
        end else if (op < 15) do_notify(16'(rnd(8)), bit'(rnd(2)));
        else do_access(16'(next_si - 1), 32'(lcg), 1, 0);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule